// File: doc/BRIEF.md
# Programmable Serial Baud-Rate Generator

This block derives the timing strobes for an asynchronous serial port from the bus clock. Software writes a 13-bit modulo divisor through two byte-wide registers on a plain write port. The generator counts bus-clock cycles against that divisor. It produces a one-cycle oversampling strobe at sixteen times the bit rate and a one-cycle bit strobe at the bit rate, so the bit rate is the bus clock divided by sixteen times the divisor.

The upper divisor field is double-buffered. A write to the high register only loads a holding latch, and the working divisor changes as a whole when the low register is written. That write also restarts both counters, so no shortened or stretched first period is produced. The strobes run only while the divisor is non-zero and at least one of the transmitter or receiver enables is high. The low register comes out of reset holding a non-zero value, but nothing toggles until an enable is raised. Both registers can be read back through a registered read port.

Top module: `baud_gen_top`

## Requirements
- R1: Register select value 1 addresses the high register, whose bits 4:0 form divisor bits 12:8. Select value 0 addresses the low register, which forms divisor bits 7:0.
- R2: For a divisor D from 1 to 8191, `os_tick` is a one-cycle pulse (or constantly high when D is 1) that repeats every D clock cycles.
- R3: `bit_tick` pulses in the same cycle as every 16th `os_tick`, so its period is 16×D cycles. It never pulses without `os_tick`.
- R4: A divisor of 0 holds both counters at zero and produces no strobes.
- R5: A high-register write changes neither the working divisor nor the strobe rate until the next low-register write. The low-register write then applies the buffered high field.
- R6: After reset the low register holds 0x04 and the high register holds 0x00. No strobe appears while both enables are low, and the first strobes appear once an enable is raised.
- R7: Strobes are produced only while `tx_en` or `rx_en` is 1. While both enables are 0, the counters are held at zero.
- R8: A low-register write restarts both counters. The first `os_tick` appears exactly D cycles after the write edge, and the first `bit_tick` appears exactly 16×D cycles after it.
- R9: A read returns, one cycle after `rd_sel` is presented, either the low register (select 0) or the working high field zero-extended (select 1). Bits 7:5 of the high register read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 low byte, 1 high byte |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 low byte, 1 high byte |
| rd_data | output | 8 | Registered read data |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| os_tick | output | 1 | Oversampling strobe, every D cycles |
| bit_tick | output | 1 | Bit-rate strobe, every 16×D cycles |

## Verification
The divisor is swept across 1, 2, 13, 300 and 8191. The smallest value shows that the strobe can stay high on consecutive cycles, 13 separates a correct modulo compare from an off-by-one, and the largest value exercises the full counter width. For each divisor, the bench measures the latency from the low-byte write to the first strobe as well as the steady period. This separates the restart behaviour from the free-running rate. A high-only write in the middle of a run, a write to the reserved bits, a zero divisor and enable toggling each target the buffering, masking and gating paths on their own.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int BUS_W      = 8;
  localparam int DIV_W      = 13;
  localparam int OS_RATIO   = 16;
  localparam logic [BUS_W-1:0] LO_RESET = 8'h04;
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = baud_gen_pkg::DIV_W,
  parameter logic [BUS_W-1:0] LO_RST = baud_gen_pkg::LO_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [BUS_W-1:0] rd_data,
  output logic [DIV_W-1:0] divisor,
  output logic             load
);
  localparam int HI_W  = DIV_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [HI_W-1:0]  hi_pend;
  logic [HI_W-1:0]  hi_work;
  logic [BUS_W-1:0] lo_q;

  assign load    = wr_en && (wr_sel == SEL_LO);
  assign divisor = {hi_work, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend <= '0;
      hi_work <= '0;
      lo_q    <= LO_RST;
    end else if (wr_en) begin
      if (wr_sel == SEL_HI) begin
        hi_pend <= wr_data[HI_W-1:0];
      end else begin
        lo_q    <= wr_data;
        hi_work <= hi_pend;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_sel == SEL_HI) begin
      rd_data <= {{PAD_W{1'b0}}, hi_work};
    end else begin
      rd_data <= lo_q;
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             wrap,
  output logic             os_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = divisor - DIV_W'(1);
  assign wrap = run && !restart && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt     <= '0;
      os_tick <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      os_tick <= 1'b1;
    end else begin
      cnt     <= cnt + DIV_W'(1);
      os_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_subdiv.sv
module baud_subdiv #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic wrap,
  output logic bit_tick
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] TOP = CW'(RATIO - 1);

  logic [CW-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      sub      <= '0;
      bit_tick <= 1'b0;
    end else if (wrap) begin
      if (sub == TOP) begin
        sub      <= '0;
        bit_tick <= 1'b1;
      end else begin
        sub      <= sub + CW'(1);
        bit_tick <= 1'b0;
      end
    end else begin
      bit_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_gen_pkg::*;
#(
  parameter int DIV_W    = baud_gen_pkg::DIV_W,
  parameter int OS_RATIO = baud_gen_pkg::OS_RATIO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [BUS_W-1:0] rd_data,
  input  logic             tx_en,
  input  logic             rx_en,
  output logic             os_tick,
  output logic             bit_tick
);
  logic [DIV_W-1:0] divisor;
  logic             load;
  logic             run;
  logic             wrap;

  baud_div_regs #(.DIV_W(DIV_W), .LO_RST(LO_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .divisor(divisor), .load(load)
  );

  assign run = (tx_en || rx_en) && (divisor != '0);

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .restart(load), .divisor(divisor),
    .wrap(wrap), .os_tick(os_tick)
  );

  baud_subdiv #(.RATIO(OS_RATIO)) u_sub (
    .clk(clk), .rst(rst), .run(run), .restart(load), .wrap(wrap),
    .bit_tick(bit_tick)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             rd_sel,
  input logic [7:0]       rd_data,
  input logic             tx_en,
  input logic             rx_en,
  input logic             os_tick,
  input logic             bit_tick,
  input logic [DIV_W-1:0] divisor
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R6: register defaults and quiet strobes straight after reset
  always @(posedge clk) begin
    if (rst_q && !rst) begin
      p_reset_vals_r6: assert (divisor == DIV_W'(4) && !os_tick && !bit_tick)
        else $error("reset state wrong");
    end
  end

  p_bit_with_os_r3: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  p_zero_div_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |=> (!os_tick && !bit_tick));

  p_hi_buffered_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> $stable(divisor));

  p_gate_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !rx_en) |=> (!os_tick && !bit_tick));

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> (!os_tick && !bit_tick));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_sel |=> (rd_data[7:5] == 3'b000));
endmodule

bind baud_gen_top baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .rd_sel(rd_sel),
  .rd_data(rd_data), .tx_en(tx_en), .rx_en(rx_en), .os_tick(os_tick),
  .bit_tick(bit_tick), .divisor(divisor)
);

// File: tb/test_baud_gen_top.sv
`timescale 1ns/1ps
module test_baud_gen_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic os_tick, bit_tick;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  baud_gen_top i_baud_gen_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tx_en(tx_en), .rx_en(rx_en),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  localparam int NV = 5;
  localparam int DIVS [NV] = '{1, 2, 13, 300, 8191};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); v = int'(rd_data);
  endtask

  // cycles from the negedge after a write edge until os_tick shows (D+1)
  task automatic latency_os(output int n);
    n = 1;
    while (!os_tick && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic latency_bit(output int n);
    n = 1;
    while (!bit_tick && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic period(input bit use_bit, output int p);
    int n = 0;
    do begin @(negedge clk); n++; end while (!(use_bit ? bit_tick : os_tick) && n < 20000);
    p = n;
  endtask

  task automatic count_ticks(input int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) c++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, p, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset values and idle
    rd(1'b0, v); check("R6 low reset", v, 4);
    rd(1'b1, v); check("R6 high reset", v, 0);
    count_ticks(80, v); check("R6 idle before enable", v, 0);
    @(negedge clk); rx_en = 1'b1;
    period(1'b0, p); period(1'b0, p); check("R6 rate after enable", p, 4);
    rx_en = 1'b0;

    // vector walk R1 R2 R3 R8
    tx_en = 1'b1;
    for (int k = 0; k < NV; k++) begin
      int d = DIVS[k];
      wr(1'b1, 8'(d >> 8));
      wr(1'b0, 8'(d));
      latency_os(n); check("R8 first os latency", n, d + 1);
      period(1'b0, p); check("R2 os period", p, d);
      if (d <= 300) begin
        wr(1'b0, 8'(d));
        latency_bit(n); check("R8 first bit latency", n, 16 * d + 1);
        period(1'b1, p); check("R3 bit period", p, 16 * d);
      end
      rd(1'b0, v); check("R1 low readback", v, d & 8'hFF);
      rd(1'b1, v); check("R1 high readback", v, d >> 8);
    end

    // R5 high-only write leaves rate unchanged
    wr(1'b1, 8'h00); wr(1'b0, 8'd13);
    wr(1'b1, 8'h05);
    period(1'b0, p); period(1'b0, p); check("R5 rate after high-only write", p, 13);
    rd(1'b1, v); check("R5 high reads working value", v, 0);
    wr(1'b0, 8'h0D);
    period(1'b0, p); period(1'b0, p); check("R5 rate after low write", p, 1293);

    // R9 reserved bits
    wr(1'b1, 8'hFF); wr(1'b0, 8'h00);
    rd(1'b1, v); check("R9 reserved bits masked", v, 8'h1F);

    // R4 zero divisor
    wr(1'b1, 8'h00); wr(1'b0, 8'h00);
    count_ticks(100, v); check("R4 zero divisor silent", v, 0);

    // R7 enable gating
    wr(1'b0, 8'd2);
    period(1'b0, p); period(1'b0, p); check("R7 running on tx_en", p, 2);
    @(negedge clk); tx_en = 1'b0;
    count_ticks(60, v); check("R7 silent with enables low", v, 0);
    @(negedge clk); rx_en = 1'b1;
    period(1'b0, p); period(1'b0, p); check("R7 running on rx_en", p, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule